// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block lets several agents share a word-addressed memory and build atomic read-modify-write sequences out of two ordinary-looking operations. A link read returns a word and arms a reservation on that word's address for the requesting agent. A later conditional write from the same agent lands only if nothing has touched that address in between. Anything that breaks the reservation makes the conditional write fail: a plain store from any agent, a winning conditional write from another agent, or an invalidation arriving on the snoop input. The agent learns the outcome from a one-bit result.

Every agent may present one request per cycle, and all agents are served in the same cycle. Each response is registered and appears one cycle after its request. It carries the word as it stood before that cycle's writes. When requests collide in one cycle, plain stores and invalidations take effect ahead of conditional writes. Among conditional writes to one address, the lowest agent index wins. Software retries a failed link/conditional pair until it succeeds, which gives fetch-and-increment, locks and similar primitives.

Top module: `llsc_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no response is valid. Every reservation starts invalid, and every memory word reads as zero.
- R2: `req_op` is encoded 00 plain load, 01 plain store, 10 link read, 11 conditional write. Every accepted request gets a response one cycle later on its own agent lane. `rsp_rdata` holds the addressed word as it was before that cycle's writes. A link read also arms the agent's reservation on the full request address.
- R3: A conditional write whose reservation is armed on the same address writes `req_wdata`, provided no conflict exists in its cycle. Its response has `rsp_sc_ok` = 1. Every response that is not a conditional write has `rsp_sc_ok` = 0.
- R4: A failing conditional write reports `rsp_sc_ok` = 0 and leaves memory unchanged. Every conditional write, whether it succeeds or fails, disarms the issuing agent's reservation.
- R5: A plain store from any agent to a reserved address disarms that reservation. This holds even when the stored value equals the current one, for example a release store of zero. A plain store in the same cycle as a conditional write to the same address makes that conditional write fail.
- R6: An invalidation on the snoop input whose address equals a reserved address disarms that reservation. A conditional write in the same cycle as an invalidation of its address fails. An invalidation of a different address leaves the reservation armed.
- R7: A conditional write to an address other than the one in the agent's reservation fails. Addresses are compared over all `ADDR_W` bits.
- R8: A successful conditional write disarms every other agent's reservation on the same address.
- R9: When several armed conditional writes to one address arrive in the same cycle, only the lowest-indexed agent succeeds. The others report 0.
- R10: A link read in the same cycle as a store, a successful conditional write or an invalidation to the same address still returns the old word. It leaves the reservation disarmed, so a following conditional write fails.
- R11: Two agents running link/increment/conditional-write loops on one counter each advance it exactly once. The loser's retry reads the winner's value and then succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_AGENTS | Request present, one bit per agent |
| req_op | input | NUM_AGENTS x 2 | Operation per agent (see R2) |
| req_addr | input | NUM_AGENTS x ADDR_W | Word address per agent |
| req_wdata | input | NUM_AGENTS x DATA_W | Store data per agent |
| snoop_inv_valid | input | 1 | Invalidation observed this cycle |
| snoop_inv_addr | input | ADDR_W | Word address of the invalidation |
| rsp_valid | output | NUM_AGENTS | Response present, one bit per agent |
| rsp_rdata | output | NUM_AGENTS x DATA_W | Word before the request's cycle |
| rsp_sc_ok | output | NUM_AGENTS | Conditional-write success flag |

## Verification
The bench builds the block with four agents, 32-bit addresses and data, and a 16-word memory. Four agents are enough for a three-way link on one address with a two-way conditional-write race, for a separate bystander agent, and for the tie-break to be observed at an index other than zero. The small memory keeps every target word distinct, so each collision in the tests comes from the scenario itself and never from address aliasing.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_STORE = 2'b01,
      OP_LINK  = 2'b10,
      OP_COND  = 2'b11
   } llsc_op_e;
endpackage

// File: rtl/llsc_prio_resolve.sv
`timescale 1ns/1ps
// Lowest index wins among requesters sharing one address.
module llsc_prio_resolve #(
   parameter int NUM_AGENTS = 4,
   parameter int ADDR_W     = 32
) (
   input  logic [NUM_AGENTS-1:0]             want,
   input  logic [NUM_AGENTS-1:0][ADDR_W-1:0] addr,
   output logic [NUM_AGENTS-1:0]             grant
);
   for (genvar gi = 0; gi < NUM_AGENTS; gi++) begin : g_lane
      logic beaten;
      always_comb begin
         beaten = 1'b0;
         for (int j = 0; j < gi; j++) begin
            if (want[j] && (addr[j] == addr[gi])) beaten = 1'b1;
         end
      end
      assign grant[gi] = want[gi] && !beaten;
   end
endmodule

// File: rtl/llsc_link_reg.sv
`timescale 1ns/1ps
// One agent's reservation: address plus armed bit, with its own watchers.
module llsc_link_reg #(
   parameter int NUM_AGENTS = 4,
   parameter int ADDR_W     = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              arm_req,
   input  logic [ADDR_W-1:0]                 arm_addr,
   input  logic                              arm_block,
   input  logic                              own_cond,
   input  logic [NUM_AGENTS-1:0]             wr_en,
   input  logic [NUM_AGENTS-1:0][ADDR_W-1:0] wr_addr,
   input  logic                              inv_valid,
   input  logic [ADDR_W-1:0]                 inv_addr,
   output logic                              link_valid,
   output logic [ADDR_W-1:0]                 link_addr
);
   logic kill;

   always_comb begin
      kill = own_cond || (inv_valid && (inv_addr == link_addr));
      for (int j = 0; j < NUM_AGENTS; j++) begin
         if (wr_en[j] && (wr_addr[j] == link_addr)) kill = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_valid <= 1'b0;
         link_addr  <= '0;
      end else if (arm_req) begin
         link_valid <= !arm_block;
         link_addr  <= arm_addr;
      end else if (kill) begin
         link_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/llsc_word_mem.sv
`timescale 1ns/1ps
// Multi-port word store: combinational reads, lowest lane wins a write clash.
module llsc_word_mem #(
   parameter int NUM_AGENTS = 4,
   parameter int DATA_W     = 32,
   parameter int DEPTH      = 16,
   localparam int IDX_W     = $clog2(DEPTH)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_AGENTS-1:0][IDX_W-1:0]  idx,
   input  logic [NUM_AGENTS-1:0]             wr_en,
   input  logic [NUM_AGENTS-1:0][DATA_W-1:0] wr_data,
   output logic [NUM_AGENTS-1:0][DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] words [DEPTH];

   for (genvar gi = 0; gi < NUM_AGENTS; gi++) begin : g_rd
      assign rd_data[gi] = words[idx[gi]];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) words[k] <= '0;
      end else begin
         for (int i = NUM_AGENTS - 1; i >= 0; i--) begin
            if (wr_en[i]) words[idx[i]] <= wr_data[i];
         end
      end
   end
endmodule

// File: rtl/llsc_monitor.sv
`timescale 1ns/1ps
module llsc_monitor
   import llsc_pkg::*;
#(
   parameter int NUM_AGENTS = 4,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int MEM_DEPTH  = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_AGENTS-1:0]             req_valid,
   input  logic [NUM_AGENTS-1:0][1:0]        req_op,
   input  logic [NUM_AGENTS-1:0][ADDR_W-1:0] req_addr,
   input  logic [NUM_AGENTS-1:0][DATA_W-1:0] req_wdata,
   input  logic                              snoop_inv_valid,
   input  logic [ADDR_W-1:0]                 snoop_inv_addr,
   output logic [NUM_AGENTS-1:0]             rsp_valid,
   output logic [NUM_AGENTS-1:0][DATA_W-1:0] rsp_rdata,
   output logic [NUM_AGENTS-1:0]             rsp_sc_ok
);
   localparam int IDX_W = $clog2(MEM_DEPTH);

   if (NUM_AGENTS < 1) begin : g_bad_agents
      $error("llsc_monitor: NUM_AGENTS must be at least 1");
   end
   if (MEM_DEPTH < 2 || (MEM_DEPTH & (MEM_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("llsc_monitor: MEM_DEPTH must be a power of two, at least 2");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("llsc_monitor: ADDR_W narrower than the memory index");
   end

   logic [NUM_AGENTS-1:0]             is_store, is_link, is_cond;
   logic [NUM_AGENTS-1:0]             lr_valid;
   logic [NUM_AGENTS-1:0][ADDR_W-1:0] lr_addr;
   logic [NUM_AGENTS-1:0]             cond_cand, cond_win, cond_ok;
   logic [NUM_AGENTS-1:0]             addr_clash, wr_en;
   logic [NUM_AGENTS-1:0][IDX_W-1:0]  mem_idx;
   logic [NUM_AGENTS-1:0][DATA_W-1:0] mem_rd;

   for (genvar gi = 0; gi < NUM_AGENTS; gi++) begin : g_agent
      llsc_op_e op;
      logic     clash_l;
      logic     block_l;

      assign op           = llsc_op_e'(req_op[gi]);
      assign is_store[gi] = req_valid[gi] && (op == OP_STORE);
      assign is_link[gi]  = req_valid[gi] && (op == OP_LINK);
      assign is_cond[gi]  = req_valid[gi] && (op == OP_COND);
      assign mem_idx[gi]  = req_addr[gi][IDX_W-1:0];

      // plain stores and invalidations rank ahead of conditional writes
      always_comb begin
         clash_l = snoop_inv_valid && (snoop_inv_addr == req_addr[gi]);
         for (int j = 0; j < NUM_AGENTS; j++) begin
            if (is_store[j] && (req_addr[j] == req_addr[gi])) clash_l = 1'b1;
         end
      end
      assign addr_clash[gi] = clash_l;

      assign cond_cand[gi] = is_cond[gi] && lr_valid[gi] && (lr_addr[gi] == req_addr[gi]);
      assign cond_ok[gi]   = cond_win[gi] && !addr_clash[gi];
      assign wr_en[gi]     = is_store[gi] || cond_ok[gi];

      // a link read racing any write to its word is not armed
      always_comb begin
         block_l = addr_clash[gi];
         for (int j = 0; j < NUM_AGENTS; j++) begin
            if (cond_ok[j] && (req_addr[j] == req_addr[gi])) block_l = 1'b1;
         end
      end

      llsc_link_reg #(
         .NUM_AGENTS (NUM_AGENTS),
         .ADDR_W     (ADDR_W)
      ) u_link (
         .clk        (clk),
         .rst_n      (rst_n),
         .arm_req    (is_link[gi]),
         .arm_addr   (req_addr[gi]),
         .arm_block  (block_l),
         .own_cond   (is_cond[gi]),
         .wr_en      (wr_en),
         .wr_addr    (req_addr),
         .inv_valid  (snoop_inv_valid),
         .inv_addr   (snoop_inv_addr),
         .link_valid (lr_valid[gi]),
         .link_addr  (lr_addr[gi])
      );
   end

   llsc_prio_resolve #(
      .NUM_AGENTS (NUM_AGENTS),
      .ADDR_W     (ADDR_W)
   ) u_cond_arb (
      .want  (cond_cand),
      .addr  (req_addr),
      .grant (cond_win)
   );

   llsc_word_mem #(
      .NUM_AGENTS (NUM_AGENTS),
      .DATA_W     (DATA_W),
      .DEPTH      (MEM_DEPTH)
   ) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (mem_idx),
      .wr_en   (wr_en),
      .wr_data (req_wdata),
      .rd_data (mem_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= '0;
         rsp_rdata <= '0;
         rsp_sc_ok <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_rdata <= mem_rd;
         rsp_sc_ok <= cond_ok;
      end
   end
endmodule

// File: rtl/llsc_monitor_chk.sv
`timescale 1ns/1ps
module llsc_monitor_chk #(
   parameter int NUM_AGENTS = 4,
   parameter int ADDR_W     = 32
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [NUM_AGENTS-1:0]             req_valid,
   input logic [NUM_AGENTS-1:0][1:0]        req_op,
   input logic [NUM_AGENTS-1:0][ADDR_W-1:0] req_addr,
   input logic                              snoop_inv_valid,
   input logic [ADDR_W-1:0]                 snoop_inv_addr,
   input logic [NUM_AGENTS-1:0]             rsp_valid,
   input logic [NUM_AGENTS-1:0]             rsp_sc_ok,
   input logic [NUM_AGENTS-1:0]             lr_valid,
   input logic [NUM_AGENTS-1:0][ADDR_W-1:0] lr_addr
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (rsp_valid == '0));

   for (genvar gi = 0; gi < NUM_AGENTS; gi++) begin : g_lane
      // R3
      cond_ok_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_sc_ok[gi] |-> (rsp_valid[gi] &&
            $past(req_valid[gi] && (req_op[gi] == 2'b11) && lr_valid[gi] &&
                  (lr_addr[gi] == req_addr[gi]))));

      // R4
      own_cond_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid[gi] && (req_op[gi] == 2'b11)) |=> !lr_valid[gi]);

      // R6
      inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (snoop_inv_valid && (snoop_inv_addr == lr_addr[gi]) &&
          !(req_valid[gi] && (req_op[gi] == 2'b10))) |=> !lr_valid[gi]);

      for (genvar gj = gi + 1; gj < NUM_AGENTS; gj++) begin : g_pair
         // R9
         single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_sc_ok[gi] && rsp_sc_ok[gj]) |-> $past(req_addr[gi] != req_addr[gj]));
      end
   end
endmodule

bind llsc_monitor llsc_monitor_chk #(
   .NUM_AGENTS (NUM_AGENTS),
   .ADDR_W     (ADDR_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .req_valid       (req_valid),
   .req_op          (req_op),
   .req_addr        (req_addr),
   .snoop_inv_valid (snoop_inv_valid),
   .snoop_inv_addr  (snoop_inv_addr),
   .rsp_valid       (rsp_valid),
   .rsp_sc_ok       (rsp_sc_ok),
   .lr_valid        (lr_valid),
   .lr_addr         (lr_addr)
);

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb;
   localparam int NA = 4;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

   typedef struct {
      int          agent;
      logic [31:0] data;
      logic        ok;
      string       tag;
   } exp_t;

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic [NA-1:0]             req_valid = '0;
   logic [NA-1:0][1:0]        req_op = '0;
   logic [NA-1:0][AW-1:0]     req_addr = '0;
   logic [NA-1:0][DW-1:0]     req_wdata = '0;
   logic                      snoop_inv_valid = 1'b0;
   logic [AW-1:0]             snoop_inv_addr = '0;
   logic [NA-1:0]             rsp_valid;
   logic [NA-1:0][DW-1:0]     rsp_rdata;
   logic [NA-1:0]             rsp_sc_ok;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   finished = 1'b0;

   always #2 clk = ~clk;

   llsc_monitor #(.NUM_AGENTS(NA), .ADDR_W(AW), .DATA_W(DW), .MEM_DEPTH(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .snoop_inv_valid(snoop_inv_valid),
      .snoop_inv_addr(snoop_inv_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_sc_ok(rsp_sc_ok));

   // driver: call in rising agent order within one cycle
   task automatic put(input int a, input logic [1:0] op, input logic [31:0] addr,
                      input logic [31:0] wd, input logic [31:0] exp_d,
                      input logic exp_ok, input string tag);
      exp_t e;
      req_valid[a] = 1'b1;
      req_op[a]    = op;
      req_addr[a]  = addr;
      req_wdata[a] = wd;
      e.agent = a; e.data = exp_d; e.ok = exp_ok; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic inv(input logic [31:0] addr);
      snoop_inv_valid = 1'b1;
      snoop_inv_addr  = addr;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      req_valid = '0;
      snoop_inv_valid = 1'b0;
   endtask

   // monitor: pop and compare as responses appear
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int a = 0; a < NA; a++) begin
            if (rsp_valid[a]) begin
               n_cmp++;
               if (exp_q.size() == 0) begin
                  n_bad++;
                  $display("FAIL R2 unexpected response agent %0d: actual data %h, expected none", a, rsp_rdata[a]);
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  if (e.agent != a || rsp_rdata[a] !== e.data || rsp_sc_ok[a] !== e.ok) begin
                     n_bad++;
                     $display("FAIL %s: actual agent %0d data %h ok %b, expected agent %0d data %h ok %b",
                              e.tag, a, rsp_rdata[a], rsp_sc_ok[a], e.agent, e.data, e.ok);
                  end
               end
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung run, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_cmp++;
      if (rsp_valid !== '0) begin
         n_bad++;
         $display("FAIL R1 reset: actual rsp_valid %b, expected 0000", rsp_valid);
      end
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      n_cmp++;
      if (rsp_valid !== '0) begin
         n_bad++;
         $display("FAIL R1 after reset: actual rsp_valid %b, expected 0000", rsp_valid);
      end
      @(posedge clk); #1;

      put(0, LD, 5, 0, 32'h0, 0, "R1 memory zero");                tick();
      // R2 / R3
      put(0, ST, 5, 32'h11, 32'h0, 0, "R2 store old word");         tick();
      put(1, LL, 5, 0, 32'h11, 0, "R2 link read");                  tick();
      put(1, SC, 5, 32'h22, 32'h11, 1, "R3 cond success");          tick();
      put(0, LD, 5, 0, 32'h22, 0, "R3 cond wrote");                 tick();
      // R4
      put(1, SC, 5, 32'h33, 32'h22, 0, "R4 cond after own cond");   tick();
      put(0, LD, 5, 0, 32'h22, 0, "R4 memory unchanged");           tick();
      // R5 other agent store
      put(0, LL, 7, 0, 32'h0, 0, "R5 link");                        tick();
      put(2, ST, 7, 32'h5, 32'h0, 0, "R5 store");                   tick();
      put(0, SC, 7, 32'h9, 32'h5, 0, "R5 cond after store");        tick();
      put(1, LD, 7, 0, 32'h5, 0, "R5 memory unchanged");            tick();
      // R5 release store of unchanged zero
      put(1, LL, 6, 0, 32'h0, 0, "R5 link zero word");              tick();
      put(3, ST, 6, 32'h0, 32'h0, 0, "R5 zero store");              tick();
      put(1, SC, 6, 32'h77, 32'h0, 0, "R5 cond after zero store");  tick();
      put(1, LD, 6, 0, 32'h0, 0, "R5 zero word kept");              tick();
      // R6 invalidation
      put(1, LL, 8, 0, 32'h0, 0, "R6 link");                        tick();
      inv(8);                                                       tick();
      put(1, SC, 8, 32'h44, 32'h0, 0, "R6 cond after inv");         tick();
      put(1, LL, 8, 0, 32'h0, 0, "R6 relink");                      tick();
      inv(9);                                                       tick();
      put(1, SC, 8, 32'h44, 32'h0, 1, "R6 other inv harmless");     tick();
      put(0, LL, 11, 0, 32'h0, 0, "R6 link b");                     tick();
      put(0, SC, 11, 32'h1, 32'h0, 0, "R6 same-cycle inv"); inv(11); tick();
      put(0, LD, 11, 0, 32'h0, 0, "R6 word untouched");             tick();
      // R7 address mismatch
      put(2, LL, 9, 0, 32'h0, 0, "R7 link");                        tick();
      put(2, SC, 10, 32'h1, 32'h0, 0, "R7 cond other address");     tick();
      put(2, LD, 10, 0, 32'h0, 0, "R7 memory unchanged");           tick();
      // R8 success clears others
      put(0, LL, 3, 0, 32'h0, 0, "R8 link a0");
      put(1, LL, 3, 0, 32'h0, 0, "R8 link a1");                     tick();
      put(1, SC, 3, 32'h7, 32'h0, 1, "R8 first cond");              tick();
      put(0, SC, 3, 32'h8, 32'h7, 0, "R8 second cond");             tick();
      put(3, LD, 3, 0, 32'h7, 0, "R8 winner value");                tick();
      // R9 same-cycle priority
      put(0, LL, 4, 0, 32'h0, 0, "R9 link a0");
      put(1, LL, 4, 0, 32'h0, 0, "R9 link a1");
      put(2, LL, 4, 0, 32'h0, 0, "R9 link a2");                     tick();
      put(1, SC, 4, 32'h1, 32'h0, 1, "R9 low index wins");
      put(2, SC, 4, 32'h2, 32'h0, 0, "R9 high index loses");        tick();
      put(0, SC, 4, 32'h3, 32'h1, 0, "R9 bystander cleared");       tick();
      put(3, LD, 4, 0, 32'h1, 0, "R9 memory");                      tick();
      // R10 link racing a store
      put(0, ST, 12, 32'h33, 32'h0, 0, "R10 store");
      put(3, LL, 12, 0, 32'h0, 0, "R10 link old word");             tick();
      put(3, SC, 12, 32'h55, 32'h33, 0, "R10 cond unarmed");        tick();
      put(3, LD, 12, 0, 32'h33, 0, "R10 memory");                   tick();
      // R11 fetch-and-increment race
      put(2, LL, 14, 0, 32'h0, 0, "R11 link a2");
      put(3, LL, 14, 0, 32'h0, 0, "R11 link a3");                   tick();
      put(2, SC, 14, 32'h1, 32'h0, 1, "R11 a2 increment");
      put(3, SC, 14, 32'h1, 32'h0, 0, "R11 a3 retry needed");       tick();
      put(3, LL, 14, 0, 32'h1, 0, "R11 a3 relink");                 tick();
      put(3, SC, 14, 32'h2, 32'h1, 1, "R11 a3 increment");          tick();
      put(0, LD, 14, 0, 32'h2, 0, "R11 counter");                   tick();

      repeat (3) tick();
      n_cmp++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R2 missing responses: actual %0d left, expected 0", exp_q.size());
      end
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule